// File: doc/BRIEF.md
# Strap-Selected Three-Source Reset Controller

This block turns up to three asynchronous, active-low external reset pins into three internal active-low reset outputs: one for the whole chip, one for the real-time-clock power domain and one for the processor subsystem. A static strap input selects the mode. In mode 0 all three pins are honoured. In mode 1 the RTC power-on pin is ignored. The processor pin is honoured in mode 1 only when a pin-function select input chooses the reset function; its default is the general-purpose function. The RTC request is also gated by a software enable bit.

The power-on pin is the cold reset. It drives every output low at once, with no clock edge needed, and it clears all other state. The other two pins are sampled into the free-running 32 kHz clock domain through a two-flop synchronizer. A width counter then accepts a request only if the pin stays low for at least two consecutive sampling edges. Every output is released synchronously, a fixed number of 32 kHz edges after its last request has gone away. A sticky flag per source records which source caused a reset. Each flag is cleared by a write-one-to-clear strobe.

Top module: `rstctl_top`

## Requirements
- R1: While `porPinN` is low, `chipRstN`, `rtcRstN` and `procRstN` are all low, with no clock edge needed. `resetFlags` reads 3'b001 (bit 0 = power-on, bit 1 = RTC, bit 2 = processor).
- R2: After `porPinN` rises with no other request pending, all three outputs are still low after the first rising edge of `clk32k`. They are high after the second.
- R3: An RTC or processor pin that is sampled low on only one rising edge of `clk32k` has no effect. When it is sampled low on two or more consecutive edges, its output goes low on the fifth rising edge. That count includes the first edge that saw it low.
- R4: An accepted request holds its output low while the pin stays low. The output goes high on the fifth rising edge, counting the first edge that samples the pin high again.
- R5: With `modeStrap` = 1, the RTC pin never pulls `rtcRstN` low.
- R6: With `rtcResetEnable` = 0, the RTC pin never pulls `rtcRstN` low.
- R7: With `modeStrap` = 1, the processor pin acts only when `procPinIsReset` = 1. With `modeStrap` = 0, it acts regardless of that select.
- R8: Only the power-on pin affects `chipRstN`. The processor pin affects only `procRstN`. The RTC pin affects only `rtcRstN`.
- R9: Flag bit 1 (RTC) or bit 2 (processor) is set on the edge where its source pulls its output low. A flag bit stays set until its `flagClear` bit is high at a rising edge of `clk32k`. The clear takes effect on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk32k | input | 1 | Free-running 32 kHz sampling clock |
| porPinN | input | 1 | Power-on (cold) reset pin, active low, asynchronous |
| rtcPorPinN | input | 1 | RTC power-domain reset pin, active low |
| procPinN | input | 1 | Processor subsystem reset pin, active low |
| modeStrap | input | 1 | Static mode select: 0 = three pins, 1 = RTC pin unused |
| rtcResetEnable | input | 1 | Software gate for the RTC reset request, 1 = enabled |
| procPinIsReset | input | 1 | Pin-function select: 1 = processor pin used as reset |
| flagClear | input | 3 | Write-one-to-clear strobes for the source flags |
| chipRstN | output | 1 | Whole-chip reset, active low |
| rtcRstN | output | 1 | RTC power-domain reset, active low |
| procRstN | output | 1 | Processor subsystem reset, active low |
| resetFlags | output | 3 | Sticky source flags {processor, RTC, power-on} |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a minimum width of two edges and a release delay of two edges. With these values a pulse of one edge falls just below the acceptance limit, and pulses of two to four edges sit at or above it. Every combination of strap, software gate and pin select is swept. Each combination is paired with pulses of each width on both gated pins. The bench computes the expected output timing, domain isolation and flag contents arithmetically from the pulse width and the configuration.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

  localparam int NUM_SRC  = 3;
  localparam int IDX_POR  = 0;
  localparam int IDX_RTC  = 1;
  localparam int IDX_PROC = 2;

  typedef enum logic {
    MODE_ALL_PINS = 1'b0,
    MODE_NO_RTC   = 1'b1
  } strapMode_e;

  typedef struct packed {
    logic               rtcTake;
    logic               procTake;
    logic [NUM_SRC-1:0] flagClr;
  } ctlStrobes_t;

endpackage

// File: rtl/rstctl_qual.sv
module rstctl_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_WIDTH   = 2
) (
  input  logic clk,
  input  logic por,
  input  logic reqRaw,
  output logic qualified
);

  localparam int CNT_W = $clog2(MIN_WIDTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_WIDTH);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       widthCnt;
  logic                   reqSync;

  // Shift the raw pin level into the 32 kHz domain
  always_ff @(posedge clk or posedge por) begin
    if (por) syncQ <= '0;
    else     syncQ <= {syncQ[SYNC_STAGES-2:0], reqRaw};
  end

  assign reqSync = syncQ[SYNC_STAGES-1];

  // Count consecutive asserted samples; restart on any deassertion
  always_ff @(posedge clk or posedge por) begin
    if (por)                    widthCnt <= '0;
    else if (!reqSync)          widthCnt <= '0;
    else if (widthCnt != CNT_MAX) widthCnt <= widthCnt + 1'b1;
  end

  assign qualified = (widthCnt == CNT_MAX);

endmodule

// File: rtl/rstctl_ctrl.sv
module rstctl_ctrl
  import rstctl_pkg::*;
(
  input  logic               rtcQual,
  input  logic               procQual,
  input  strapMode_e         mode,
  input  logic               rtcResetEnable,
  input  logic               procPinIsReset,
  input  logic [NUM_SRC-1:0] flagClear,
  output ctlStrobes_t        strobes
);

  logic rtcAllowed;
  logic procAllowed;

  always_comb begin
    rtcAllowed  = 1'b0;
    procAllowed = 1'b0;
    unique case (mode)
      MODE_ALL_PINS: begin
        rtcAllowed  = rtcResetEnable;
        procAllowed = 1'b1;
      end
      MODE_NO_RTC: begin
        rtcAllowed  = 1'b0;
        procAllowed = procPinIsReset;
      end
      default: ;
    endcase
  end

  always_comb begin
    strobes          = '0;
    strobes.rtcTake  = rtcQual & rtcAllowed;
    strobes.procTake = procQual & procAllowed;
    strobes.flagClr  = flagClear;
  end

endmodule

// File: rtl/rstctl_datapath.sv
module rstctl_datapath
  import rstctl_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int MIN_WIDTH      = 2,
  parameter int RELEASE_CYCLES = 2
) (
  input  logic               clk,
  input  logic               porPinN,
  input  logic               rtcPinN,
  input  logic               procPinN,
  input  ctlStrobes_t        strobes,
  output logic               rtcQual,
  output logic               procQual,
  output logic [NUM_SRC-1:0] domRst,
  output logic [NUM_SRC-1:0] flags
);

  localparam int NUM_GATED = NUM_SRC - 1;
  localparam int REL_W     = $clog2(RELEASE_CYCLES + 1);
  localparam logic [REL_W-1:0] REL_LOAD = REL_W'(RELEASE_CYCLES);

  logic                 por;
  logic [NUM_GATED-1:0] rawReq;
  logic [NUM_GATED-1:0] qualVec;
  logic [NUM_SRC-1:0]   takeVec;

  assign por    = ~porPinN;
  assign rawReq = {~procPinN, ~rtcPinN};

  genvar g;
  generate
    for (g = 0; g < NUM_GATED; g++) begin : g_qual
      rstctl_qual #(
        .SYNC_STAGES(SYNC_STAGES),
        .MIN_WIDTH  (MIN_WIDTH)
      ) i_qual (
        .clk      (clk),
        .por      (por),
        .reqRaw   (rawReq[g]),
        .qualified(qualVec[g])
      );
    end
  endgenerate

  assign rtcQual  = qualVec[0];
  assign procQual = qualVec[1];

  always_comb begin
    takeVec           = '0;
    takeVec[IDX_RTC]  = strobes.rtcTake;
    takeVec[IDX_PROC] = strobes.procTake;
  end

  // Per-domain hold counter: async assert on POR, sync release
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_dom
      logic [REL_W-1:0] holdCnt;
      always_ff @(posedge clk or posedge por) begin
        if (por) begin
          holdCnt   <= REL_LOAD;
          domRst[g] <= 1'b1;
        end else if (takeVec[g]) begin
          holdCnt   <= REL_LOAD;
          domRst[g] <= 1'b1;
        end else if (holdCnt > REL_W'(1)) begin
          holdCnt   <= holdCnt - 1'b1;
        end else begin
          holdCnt   <= '0;
          domRst[g] <= 1'b0;
        end
      end
    end
  endgenerate

  // Sticky source flags; a set in the same cycle overrides a clear
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_flag
      always_ff @(posedge clk or posedge por) begin
        if (por) flags[g] <= (g == IDX_POR);
        else     flags[g] <= takeVec[g] | (flags[g] & ~strobes.flagClr[g]);
      end
    end
  endgenerate

endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
  import rstctl_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int MIN_WIDTH      = 2,
  parameter int RELEASE_CYCLES = 2
) (
  input  logic       clk32k,
  input  logic       porPinN,
  input  logic       rtcPorPinN,
  input  logic       procPinN,
  input  logic       modeStrap,
  input  logic       rtcResetEnable,
  input  logic       procPinIsReset,
  input  logic [2:0] flagClear,
  output logic       chipRstN,
  output logic       rtcRstN,
  output logic       procRstN,
  output logic [2:0] resetFlags
);

  ctlStrobes_t        strobes;
  logic               rtcQual;
  logic               procQual;
  logic [NUM_SRC-1:0] domRst;

  rstctl_ctrl i_ctrl (
    .rtcQual       (rtcQual),
    .procQual      (procQual),
    .mode          (strapMode_e'(modeStrap)),
    .rtcResetEnable(rtcResetEnable),
    .procPinIsReset(procPinIsReset),
    .flagClear     (flagClear),
    .strobes       (strobes)
  );

  rstctl_datapath #(
    .SYNC_STAGES   (SYNC_STAGES),
    .MIN_WIDTH     (MIN_WIDTH),
    .RELEASE_CYCLES(RELEASE_CYCLES)
  ) i_dp (
    .clk     (clk32k),
    .porPinN (porPinN),
    .rtcPinN (rtcPorPinN),
    .procPinN(procPinN),
    .strobes (strobes),
    .rtcQual (rtcQual),
    .procQual(procQual),
    .domRst  (domRst),
    .flags   (resetFlags)
  );

  assign chipRstN = ~domRst[IDX_POR];
  assign rtcRstN  = ~domRst[IDX_RTC];
  assign procRstN = ~domRst[IDX_PROC];

endmodule

// File: rtl/rstctl_checker.sv
module rstctl_checker (
  input logic       clk32k,
  input logic       porPinN,
  input logic       modeStrap,
  input logic       rtcResetEnable,
  input logic       procPinIsReset,
  input logic       chipRstN,
  input logic       rtcRstN,
  input logic       procRstN,
  input logic [2:0] resetFlags
);

  // R1: cold reset holds every domain and the flag pattern
  always @(negedge clk32k) begin
    if (!porPinN) begin
      p_por_all_low_r1: assert (!chipRstN && !rtcRstN && !procRstN && resetFlags == 3'b001)
        else $error("power-on reset did not hold all domains");
    end
  end

  // R8: nothing but power-on pulls the chip domain low
  p_chip_only_por_r8: assert property (@(posedge clk32k) disable iff (!porPinN)
    chipRstN |=> chipRstN);

  // R5: strap mode 1 ignores the RTC pin
  p_mode1_rtc_ignored_r5: assert property (@(posedge clk32k) disable iff (!porPinN)
    (modeStrap && rtcRstN) |=> rtcRstN);

  // R6: software gate blocks the RTC pin
  p_gate_blocks_rtc_r6: assert property (@(posedge clk32k) disable iff (!porPinN)
    (!rtcResetEnable && rtcRstN) |=> rtcRstN);

  // R7: in mode 1 the processor pin needs the reset function selected
  p_pinsel_proc_r7: assert property (@(posedge clk32k) disable iff (!porPinN)
    (modeStrap && !procPinIsReset && procRstN) |=> procRstN);

endmodule

bind rstctl_top rstctl_checker i_rstctl_checker (
  .clk32k        (clk32k),
  .porPinN       (porPinN),
  .modeStrap     (modeStrap),
  .rtcResetEnable(rtcResetEnable),
  .procPinIsReset(procPinIsReset),
  .chipRstN      (chipRstN),
  .rtcRstN       (rtcRstN),
  .procRstN      (procRstN),
  .resetFlags    (resetFlags)
);

// File: tb/test_rstctl_top.sv
module test_rstctl_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk32k = 1'b0;
  logic       porPinN = 1'b1;
  logic       rtcPorPinN = 1'b1;
  logic       procPinN = 1'b1;
  logic       modeStrap = 1'b0;
  logic       rtcResetEnable = 1'b0;
  logic       procPinIsReset = 1'b0;
  logic [2:0] flagClear = 3'b000;
  logic       chipRstN;
  logic       rtcRstN;
  logic       procRstN;
  logic [2:0] resetFlags;

  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk32k = ~clk32k;

  rstctl_top i_rstctl_top (
    .clk32k        (clk32k),
    .porPinN       (porPinN),
    .rtcPorPinN    (rtcPorPinN),
    .procPinN      (procPinN),
    .modeStrap     (modeStrap),
    .rtcResetEnable(rtcResetEnable),
    .procPinIsReset(procPinIsReset),
    .flagClear     (flagClear),
    .chipRstN      (chipRstN),
    .rtcRstN       (rtcRstN),
    .procRstN      (procRstN),
    .resetFlags    (resetFlags)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk32k);
  endtask

  // Cold reset, then synchronous release
  task automatic do_por();
    @(negedge clk32k);
    #(CLK_PERIOD/4);
    porPinN = 1'b0;
    #1;
    check("R1 outputs low without edge", {1'b0, chipRstN, rtcRstN, procRstN}, 4'h0);
    check("R1 flags after power-on", {1'b0, resetFlags}, 4'h1);
    edges(2);
    porPinN = 1'b1;
    edges(1);
    check("R2 still low after first edge", {1'b0, chipRstN, rtcRstN, procRstN}, 4'h0);
    edges(1);
    check("R2 released after second edge", {1'b0, chipRstN, rtcRstN, procRstN}, 4'h7);
  endtask

  task automatic clear_flags(input logic [2:0] mask, input logic [2:0] expAfter);
    flagClear = mask;
    edges(1);
    flagClear = 3'b000;
    check("R9 flags after clear", {1'b0, resetFlags}, {1'b0, expAfter});
  endtask

  // Pulse one gated pin low for w sampling edges; isProc picks the pin
  task automatic pulse(input bit isProc, input int w, input bit expTake);
    logic domOut;
    logic otherOut;
    logic expLow;
    if (isProc) procPinN = 1'b0; else rtcPorPinN = 1'b0;
    edges(w);
    if (isProc) procPinN = 1'b1; else rtcPorPinN = 1'b1;
    edges(5 - w);
    expLow   = expTake;
    domOut   = isProc ? procRstN : rtcRstN;
    otherOut = isProc ? rtcRstN : procRstN;
    check(isProc ? "R3 proc output at fifth edge" : "R3 rtc output at fifth edge",
          {3'b0, domOut}, {3'b0, ~expLow});
    check("R8 other domains untouched", {2'b0, chipRstN, otherOut}, 4'h3);
    check(isProc ? "R9 proc flag" : "R9 rtc flag", {1'b0, resetFlags},
          isProc ? {1'b0, expTake, 2'b00} : {2'b00, expTake, 1'b0});
    if (w >= 2) begin
      edges(w - 1);
      domOut = isProc ? procRstN : rtcRstN;
      check("R4 held until release edge", {3'b0, domOut}, {3'b0, ~expLow});
    end
    edges(1);
    domOut = isProc ? procRstN : rtcRstN;
    check("R4 released on fifth edge after pin high", {3'b0, domOut}, 4'h1);
    check("R9 flag sticky after release", {1'b0, resetFlags},
          isProc ? {1'b0, expTake, 2'b00} : {2'b00, expTake, 1'b0});
    clear_flags(3'b110, 3'b000);
  endtask

  initial begin
    #2;
    porPinN = 1'b0;
    for (int cfg = 0; cfg < 8; cfg++) begin
      modeStrap      = cfg[0];
      rtcResetEnable = cfg[1];
      procPinIsReset = cfg[2];
      do_por();
      clear_flags(3'b111, 3'b000);
      for (int w = 1; w <= 4; w++) begin
        // R5 R6: rtc accepted only in mode 0 with the gate enabled
        pulse(1'b0, w, (w >= 2) && !modeStrap && rtcResetEnable);
        // R7: proc accepted in mode 0, or in mode 1 with reset function selected
        pulse(1'b1, w, (w >= 2) && (!modeStrap || procPinIsReset));
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk32k);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule